// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block keeps a six-byte instruction queue topped up ahead of the decode side. It holds a 16-bit code segment value and a 16-bit fetch offset. From these it forms a 20-bit physical address and issues reads over a 16-bit memory port. An even offset brings in a whole word in one read. An odd offset brings in only the byte on the upper lane. The bytes that arrive are appended to a small circular queue. The consumer drains them one per cycle over a valid/ready byte port, strictly in the order they were fetched.

A redirect input loads a new segment and offset and throws away everything in the queue. If the memory still owes a response to a read issued before the redirect, that response is swallowed when it arrives. When no read is owed, the first request to the new address goes out in the cycle right after the redirect. At most one read is in flight at any time. A new read is started only when the queue has room for every byte that read will return.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high, out_valid and mem_req_valid are 0. The first read after reset targets the reset segment 16'hFFFF and reset offset 16'h0000.
- R2: mem_req_addr equals (segment × 16 + offset) truncated to 20 bits. The addition may overflow past 20 bits, and that carry is dropped.
- R3: For an even offset, mem_req_word is 1. The response byte on bits [7:0] is delivered before the byte on bits [15:8]. The offset then advances by 2.
- R4: For an odd offset, mem_req_word is 0. Only bits [15:8] of the response are queued, and the offset advances by 1.
- R5: The queue never holds more than 6 bytes. A word read is issued only with at least 2 free slots, and a byte read with at least 1. With the consumer stalled, the queue fills to 6 bytes from an even start and to 5 bytes from an odd start.
- R6: Bytes leave in fetch order, at most one per cycle, on each cycle where out_valid and out_ready are both 1. An unaccepted byte stays on out_byte unchanged.
- R7: At most one read is outstanding. A request that is not yet accepted keeps its address and width until mem_req_ready is 1, unless a redirect intervenes.
- R8: On the cycle after redir_valid, out_valid is 0. Responses to reads accepted up to and including the redirect edge are discarded. If no read is owed, mem_req_valid is 1 on that next cycle with the new address. A byte handed over in the redirect cycle itself counts as delivered.
- R9: The offset wraps from 16'hFFFF to 16'h0000 without changing the segment value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Load a new segment and offset and discard queued bytes |
| redir_seg | input | 16 | New code segment value |
| redir_off | input | 16 | New fetch offset |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 20 | Physical byte address of the read |
| mem_req_word | output | 1 | 1 = two-byte read at an even address, 0 = upper-lane byte at an odd address |
| mem_rsp_valid | input | 1 | Read data present, one cycle per accepted request |
| mem_rsp_data | input | 16 | Read data, even byte on [7:0], odd byte on [15:8] |
| out_valid | output | 1 | A queued byte is available |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_byte | output | 8 | Oldest queued byte |

## Verification
Several properties are checked on every cycle:
- the occupancy bound and the free-slot test on each write;
- the stability of a waiting request and of an unaccepted output byte;
- the offset step of 1 or 2 chosen by parity;
- the unchanged segment on advance;
- the empty queue after a redirect.

Some behaviours can only be shown by the bench's scenarios, which compare full streams with an arithmetic memory model:
- that bytes arrive in the right lane order;
- that stale responses never reach the consumer;
- that addresses wrap correctly at the 16-bit and 20-bit limits;
- that the queue fills exactly to 5 or 6 bytes depending on start parity.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DROP = 2'd3
  } fetch_st_e;

  typedef logic [7:0] ibyte_t;

endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter logic [SEG_W-1:0] RST_SEG = '1,
  parameter logic [OFF_W-1:0] RST_OFF = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEG_W-1:0]  load_seg,
  input  logic [OFF_W-1:0]  load_off,
  input  logic              advance,
  output logic [ADDR_W-1:0] phys,
  output logic              off_odd
);

  localparam int SW = SEG_W + SEG_SHIFT;

  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] step;
  logic [SW-1:0]    seg_base;

  // odd offset steps by one byte, even by one word
  always_comb step = {{(OFF_W-2){1'b0}}, ~off_q[0], off_q[0]};
  always_comb seg_base = {seg_q, {SEG_SHIFT{1'b0}}};
  always_comb phys = ADDR_W'(seg_base) + ADDR_W'(off_q);
  always_comb off_odd = off_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= RST_SEG;
      off_q <= RST_OFF;
    end else if (load) begin
      seg_q <= load_seg;
      off_q <= load_off;
    end else if (advance) begin
      off_q <= off_q + step;
    end
  end

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> $stable(seg_q));

  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !off_q[0]) |=> (off_q == $past(off_q) + OFF_W'(2)));

  // R4
  byte_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && off_q[0]) |=> (off_q == $past(off_q) + OFF_W'(1)));

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redir,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             off_odd,
  input  logic [CNT_W-1:0] fill,
  output logic             req_valid,
  output logic             req_word,
  output logic             advance,
  output logic             wr_en,
  output logic             wr_two
);

  fetch_st_e st_q, st_d;
  logic      word_q;
  logic      room;
  logic      owed_after;
  logic      accept;

  always_comb room = (int'(DEPTH) - int'(fill)) >= (off_odd ? 1 : 2);
  always_comb accept = (st_q == ST_REQ) && req_ready;

  // a read is still owed after this edge if it is accepted now or
  // was in flight and its data is not arriving now
  always_comb owed_after = accept ||
    (((st_q == ST_WAIT) || (st_q == ST_DROP)) && !rsp_valid);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (room)      st_d = ST_REQ;
      ST_REQ:  if (req_ready) st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) st_d = ST_IDLE;
      ST_DROP: if (rsp_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (redir) st_d = owed_after ? ST_DROP : ST_REQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      word_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) word_q <= !off_odd;
    end
  end

  always_comb begin
    req_valid = (st_q == ST_REQ);
    req_word  = !off_odd;
    advance   = accept && !redir;
    wr_en     = (st_q == ST_WAIT) && rsp_valid && !redir;
    wr_two    = word_q;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !redir) |=> (req_valid && $stable(req_word)));

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);

endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PTR_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             wr_two,
  input  ibyte_t           wr_b0,
  input  ibyte_t           wr_b1,
  input  logic             rd_ready,
  output logic             rd_valid,
  output ibyte_t           rd_byte,
  output logic [CNT_W-1:0] count
);

  ibyte_t           mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       wr_n;
  logic             pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_n   = wr_en ? (wr_two ? 2'd2 : 2'd1) : 2'd0;
    pop    = rd_valid && rd_ready;
    wr_nxt = ptr_inc(wr_ptr_q);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (int'(wr_ptr_q) == i))
        mem_q[i] <= wr_b0;
      else if (wr_en && wr_two && (int'(wr_nxt) == i))
        mem_q[i] <= wr_b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_two ? ptr_inc(wr_nxt) : wr_nxt;
      if (pop)   rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(wr_n) - CNT_W'(pop);
    end
  end

  always_comb begin
    rd_valid = (cnt_q != '0);
    rd_byte  = mem_q[rd_ptr_q];
    count    = cnt_q;
  end

  // R5
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= DEPTH);

  // R5
  write_room_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((DEPTH - int'(cnt_q)) >= int'(wr_n)));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !clr) |=> (rd_valid && $stable(rd_byte)));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH     = 6,
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter logic [SEG_W-1:0] RST_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RST_OFF = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redir_valid,
  input  logic [SEG_W-1:0]  redir_seg,
  input  logic [OFF_W-1:0]  redir_off,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_word,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             advance, off_odd, wr_en, wr_two;
  logic [CNT_W-1:0] fill;
  ibyte_t           lane0, lane1;

  // byte reads return their byte on the upper lane
  always_comb begin
    lane0 = wr_two ? mem_rsp_data[7:0] : mem_rsp_data[15:8];
    lane1 = mem_rsp_data[15:8];
  end

  pfq_addr_gen #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W),
    .RST_SEG(RST_SEG), .RST_OFF(RST_OFF)
  ) u_addr (
    .clk(clk), .rst(rst), .load(redir_valid), .load_seg(redir_seg),
    .load_off(redir_off), .advance(advance), .phys(mem_req_addr),
    .off_odd(off_odd)
  );

  pfq_fetch_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .redir(redir_valid), .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid), .off_odd(off_odd), .fill(fill),
    .req_valid(mem_req_valid), .req_word(mem_req_word), .advance(advance),
    .wr_en(wr_en), .wr_two(wr_two)
  );

  pfq_byte_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(redir_valid), .wr_en(wr_en), .wr_two(wr_two),
    .wr_b0(lane0), .wr_b1(lane1), .rd_ready(out_ready), .rd_valid(out_valid),
    .rd_byte(out_byte), .count(fill)
  );

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !out_valid);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready && !redir_valid) |=> $stable(mem_req_addr));

endmodule

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_seg = '0, redir_off = '0;
  logic        mem_req_valid, mem_req_word;
  logic        mem_req_ready = 1'b0;
  logic [19:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prefetch_queue i_prefetch_queue (
    .clk(clk), .rst(rst), .redir_valid(redir_valid), .redir_seg(redir_seg),
    .redir_off(redir_off), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_word(mem_req_word), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  // bench state
  int          cnt = 0, lat = 1, rp = 0, op = 0, rsp_cnt = 0, rq_bytes = 0;
  bit          outstanding = 0, pend_word = 0, chk_after = 0, chk_idle = 0;
  bit          do_redir = 0, wrapped = 0;
  logic [19:0] pend_addr = '0;
  logic [15:0] exp_seg = 16'hFFFF, exp_off = 16'h0000;
  logic [15:0] rq_seg = 16'hFFFF, rq_off = 16'h0000;
  logic [15:0] nr_seg = '0, nr_off = '0;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [19:0] t;
    t = {s, 4'h0} + {4'h0, o};
    return t;
  endfunction

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ {a[10:8], 5'h0};
  endfunction

  function automatic bit pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 2) == 0;
      2: return (c % 3) == 0;
      3: return ((c / 7) % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit was_out, rdy;
    int n;
    @(negedge clk);
    cnt++;
    if (chk_after) begin
      chk(!out_valid, "R8", "out_valid after redirect", 32'(out_valid), 32'd0);
      if (chk_idle)
        chk(mem_req_valid && mem_req_addr == phys(rq_seg, rq_off), "R8",
            "request right after redirect", 32'({mem_req_valid, mem_req_addr}),
            32'({1'b1, phys(rq_seg, rq_off)}));
      chk_after = 0;
    end
    if (outstanding)
      chk(!mem_req_valid, "R7", "request while read owed", 32'(mem_req_valid), 32'd0);
    // responder
    was_out = outstanding;
    mem_rsp_valid = 1'b0;
    if (outstanding) begin
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = pend_word ? {mbyte(pend_addr + 20'd1), mbyte(pend_addr)}
                                 : {mbyte(pend_addr), 8'hA5};
        outstanding = 0;
      end else rsp_cnt--;
    end
    rdy = !was_out && pat(rp, cnt);
    mem_req_ready = rdy;
    if (rdy && mem_req_valid) begin
      chk(mem_req_addr == phys(rq_seg, rq_off), wrapped ? "R9" : "R2",
          "request address", 32'(mem_req_addr), 32'(phys(rq_seg, rq_off)));
      chk(mem_req_word == !rq_off[0], rq_off[0] ? "R4" : "R3",
          "request width", 32'(mem_req_word), 32'(!rq_off[0]));
      pend_addr = mem_req_addr;
      pend_word = mem_req_word;
      outstanding = 1;
      rsp_cnt = lat - 1;
      n = rq_off[0] ? 1 : 2;
      wrapped = (32'(rq_off) + n) > 32'hFFFF;
      rq_bytes += n;
      rq_off += 16'(n);
    end
    // consumer
    out_ready = pat(op, cnt);
    if (out_ready && out_valid) begin
      chk(out_byte == mbyte(phys(exp_seg, exp_off)), "R6", "delivered byte",
          32'(out_byte), 32'(mbyte(phys(exp_seg, exp_off))));
      exp_off++;
    end
    // redirect
    redir_valid = 1'b0;
    if (do_redir) begin
      redir_valid = 1'b1;
      redir_seg = nr_seg;
      redir_off = nr_off;
      exp_seg = nr_seg; exp_off = nr_off;
      rq_seg = nr_seg;  rq_off = nr_off;
      rq_bytes = 0;
      wrapped = 0;
      chk_after = 1;
      chk_idle = !outstanding;
      do_redir = 0;
    end
  endtask

  task automatic redirect_to(input logic [15:0] s, input logic [15:0] o);
    nr_seg = s; nr_off = o; do_redir = 1;
    cyc();
  endtask

  function automatic int fill_of(input logic [15:0] o);
    int free = 6, f = 0, n;
    logic [15:0] x = o;
    while (1) begin
      n = x[0] ? 1 : 2;
      if (free < n) break;
      free -= n; f += n; x += 16'(n);
    end
    return f;
  endfunction

  logic [15:0] segs [4] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5};
  logic [15:0] offs [4] = '{16'hFFFF, 16'h0020, 16'h0003, 16'hFFFE};

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !mem_req_valid, "R1", "outputs in reset",
          32'({out_valid, mem_req_valid}), 32'd0);
    end
    rst = 1'b0;
    // R1 first stream from reset address
    repeat (40) cyc();
    chk(exp_off > 16'd10, "R1", "bytes delivered after reset", 32'(exp_off), 32'd11);

    // R5 fill level with stalled consumer
    for (int k = 0; k < 4; k++) begin
      lat = 1; rp = 0; op = 4;
      redirect_to(segs[k], offs[k]);
      repeat (40) cyc();
      chk(rq_bytes == fill_of(offs[k]), "R5", "bytes fetched while stalled",
          32'(rq_bytes), 32'(fill_of(offs[k])));
      op = 0;
      repeat (30) cyc();
    end

    // sweep latencies, memory and consumer patterns, start points
    for (int l = 1; l <= 3; l++)
      for (int r = 0; r < 3; r++)
        for (int o = 0; o < 4; o++)
          for (int k = 0; k < 4; k++) begin
            lat = l; rp = r; op = o;
            redirect_to(segs[k], offs[k] + 16'(o));
            repeat (20 + k + l) cyc();
          end

    // R8 back-to-back redirects and redirect while a read is owed
    lat = 4; rp = 0; op = 0;
    for (int k = 0; k < 4; k++) begin
      redirect_to(segs[k], offs[k]);
      redirect_to(segs[(k + 1) % 4], offs[(k + 2) % 4]);
      repeat (2 + k) cyc();
      redirect_to(segs[(k + 3) % 4], offs[k] ^ 16'h0101);
      repeat (30) cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule